// File: doc/BRIEF.md
# Board Interrupt Aggregator Register Block

This block gathers sixteen external level-sensitive interrupt lines onto a single parent interrupt output. It also provides a small bank of general-purpose board control storage: two LED data words, an LED control word, a switch word, three miscellaneous write words, a miscellaneous read word and two card-slot words. Software reaches all of it through a simple synchronous register bus with a write strobe and a read strobe.

Every clock, the block compares each interrupt line against its own registered copy of the previous level. A change on a line whose enable bit is set does two things. It overwrites the pending register with a one-hot word that names only that line, and it drives the parent output to the line's new level. The pending register therefore names only the latest enabled source and does not gather bits. The parent follows that one source and is not an OR of all lines. Changes on disabled lines are recorded in the level copy and go no further. Writes to the enable and pending registers pass through the fixed filter 0x000FEEFF, so lines 8 and 12 can never be enabled.

Top module: `brd_irq_agg`

## Requirements
- R1: After a synchronous active-high reset, every register reads zero, the parent output is 0 and the recorded input levels are all 0.
- R2: The ten storage registers at offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88, 0x90, 0xE0 and 0xE4 read back the last full 32-bit value written. Read data appears on the clock after the read strobe and is zero whenever no read was requested.
- R3: A write to the enable register at offset 0xC0 stores write data AND 0x000FEEFF. Enable bit i, for i in 0..15, gates input i, so inputs 8 and 12 are never enabled.
- R4: A write to the pending register at offset 0xD0 stores write data AND 0x000FEEFF.
- R5: On the clock edge that first samples an enabled input at a new level, the pending register becomes 1 shifted left by that input's number, and the parent output takes the input's new level.
- R6: A level change on an input whose enable bit is clear leaves both the pending register and the parent output unchanged.
- R7: When several enabled inputs change on the same edge, the lowest-numbered one is captured.
- R8: Reads from offsets outside the map return zero, and writes to them change no register.
- R9: Only address bits [7:0] select a register; the upper bits of the 20-bit address are ignored.
- R10: When a bus write to the pending register falls on the same edge as an enabled input change, the hardware capture wins.
- R11: The level copy follows disabled inputs too. Enabling a line that already sits at a new level raises no event, and its next change is captured against the recorded level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 20 | Byte address within the 1 MiB window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 16 | External interrupt levels |
| irq_parent | output | 1 | Parent interrupt level |

## Verification
A software write to the pending register and a hardware capture can target that register on the same clock edge. The bench causes this by presenting a bus write of 0xF0 to offset 0xD0 in the same half-cycle that an enabled line 0 rises. It then reads the pending register back and expects 0x1 with the parent high, which shows the capture won. A second overlap puts a mask write on the same edge as a line change. The change is judged against the mask value held before that write.

// File: rtl/brd_irq_pkg.sv
package brd_irq_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 20;
    localparam int OFF_W     = 8;
    localparam int SRC_N     = 16;
    localparam int STORE_N   = 10;
    localparam logic [DATA_W-1:0] IRQ_WR_FILTER = 32'h000F_EEFF;

    typedef enum logic [OFF_W-1:0] {
        OFF_LED_A   = 8'h10,
        OFF_LED_B   = 8'h14,
        OFF_LED_CTL = 8'h40,
        OFF_SWITCH  = 8'h60,
        OFF_MISC_W1 = 8'h80,
        OFF_MISC_W2 = 8'h84,
        OFF_MISC_W3 = 8'h88,
        OFF_MISC_RD = 8'h90,
        OFF_IRQ_EN  = 8'hC0,
        OFF_IRQ_PND = 8'hD0,
        OFF_SLOT_A  = 8'hE0,
        OFF_SLOT_B  = 8'hE4
    } reg_off_e;

    typedef struct packed {
        logic               wr;
        logic               rd;
        logic [OFF_W-1:0]   off;
        logic [DATA_W-1:0]  wdata;
    } bus_req_t;

    // Offset of plain storage slot idx.
    function automatic logic [OFF_W-1:0] store_offset(input int idx);
        case (idx)
            0: return OFF_LED_A;
            1: return OFF_LED_B;
            2: return OFF_LED_CTL;
            3: return OFF_SWITCH;
            4: return OFF_MISC_W1;
            5: return OFF_MISC_W2;
            6: return OFF_MISC_W3;
            7: return OFF_MISC_RD;
            8: return OFF_SLOT_A;
            default: return OFF_SLOT_B;
        endcase
    endfunction
endpackage

// File: rtl/brd_store_bank.sv
module brd_store_bank
    import brd_irq_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int N  = STORE_N
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output logic     rd_hit,
    output logic [DW-1:0] rd_val
);
    logic [DW-1:0] slot_q [N];
    logic [N-1:0]  sel;

    for (genvar g = 0; g < N; g++) begin : g_slot
        assign sel[g] = (req.off == store_offset(g));
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '0;
            else if (req.wr && sel[g])
                slot_q[g] <= req.wdata[DW-1:0];
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < N; i++)
            if (sel[i]) rd_val = slot_q[i];
    end
    assign rd_hit = |sel;

    a_r2_one_slot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));
endmodule

// File: rtl/brd_irq_ctl.sv
module brd_irq_ctl
    import brd_irq_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int SRCS = SRC_N
) (
    input  logic            clk,
    input  logic            rst,
    input  bus_req_t        req,
    input  logic [SRCS-1:0] irq_in,
    output logic [DW-1:0]   en_q,
    output logic [DW-1:0]   pend_q,
    output logic            irq_parent
);
    localparam int IDX_W = $clog2(SRCS);

    logic [SRCS-1:0]  lvl_q;
    logic [SRCS-1:0]  en_chg;
    logic [IDX_W-1:0] win_idx;
    logic             en_wr, pend_wr;

    assign en_wr   = req.wr && (req.off == OFF_IRQ_EN);
    assign pend_wr = req.wr && (req.off == OFF_IRQ_PND);
    assign en_chg  = (irq_in ^ lvl_q) & en_q[SRCS-1:0];

    // Lowest-numbered enabled change wins.
    always_comb begin
        win_idx = '0;
        for (int i = SRCS - 1; i >= 0; i--)
            if (en_chg[i]) win_idx = IDX_W'(i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q      <= '0;
            en_q       <= '0;
            pend_q     <= '0;
            irq_parent <= 1'b0;
        end else begin
            lvl_q <= irq_in;
            if (en_wr)
                en_q <= req.wdata & IRQ_WR_FILTER;
            if (|en_chg) begin
                pend_q     <= DW'(1) << win_idx;
                irq_parent <= irq_in[win_idx];
            end else if (pend_wr) begin
                pend_q <= req.wdata & IRQ_WR_FILTER;
            end
        end
    end

    a_r5_pend_onehot: assert property (@(posedge clk) disable iff (rst)
        (|en_chg) |=> $onehot(pend_q));
    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        (|en_chg) |=> (((pend_q[SRCS-1:0] & $past(en_chg)) != '0) &&
                       (((pend_q[SRCS-1:0] - 1'b1) & $past(en_chg)) == '0)));
    a_r5_parent_level: assert property (@(posedge clk) disable iff (rst)
        (|en_chg) |=> (irq_parent == |(pend_q[SRCS-1:0] & lvl_q)));
    a_r6_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        (!(|en_chg) && !pend_wr) |=> ($stable(pend_q) && $stable(irq_parent)));
    a_r3_never_enabled: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (en_q[8] == 1'b0 && en_q[12] == 1'b0));
endmodule

// File: rtl/brd_irq_agg.sv
module brd_irq_agg
    import brd_irq_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int AW   = ADDR_W,
    parameter int SRCS = SRC_N
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic            bus_rd,
    output logic [DW-1:0]   bus_rdata,
    input  logic [SRCS-1:0] irq_in,
    output logic            irq_parent
);
    bus_req_t      req;
    logic          st_hit;
    logic [DW-1:0] st_val, en_q, pend_q, rd_next;

    always_comb begin
        req.wr    = bus_wr;
        req.rd    = bus_rd;
        req.off   = bus_addr[OFF_W-1:0];
        req.wdata = bus_wdata;
    end

    brd_store_bank #(.DW(DW), .N(STORE_N)) u_store (
        .clk(clk), .rst(rst), .req(req), .rd_hit(st_hit), .rd_val(st_val)
    );

    brd_irq_ctl #(.DW(DW), .SRCS(SRCS)) u_irq (
        .clk(clk), .rst(rst), .req(req), .irq_in(irq_in),
        .en_q(en_q), .pend_q(pend_q), .irq_parent(irq_parent)
    );

    always_comb begin
        if (st_hit)                   rd_next = st_val;
        else if (req.off == OFF_IRQ_EN)  rd_next = en_q;
        else if (req.off == OFF_IRQ_PND) rd_next = pend_q;
        else                          rd_next = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
        else             bus_rdata <= '0;
    end

    a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/brd_irq_agg_test.sv
`timescale 1ns/1ps
module brd_irq_agg_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_in = '0;
    logic        irq_parent;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    brd_irq_agg uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_parent(irq_parent)
    );

    localparam logic [7:0] STORE_OFF [10] =
        '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88, 8'h90, 8'hE0, 8'hE4};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [19:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [19:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic set_in(input logic [15:0] v);
        irq_in = v;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 parent", {31'b0, irq_parent}, 32'h0);
        for (int i = 0; i < 10; i++) begin
            rd({12'h0, STORE_OFF[i]}, d);
            check("R1 store", d, 32'h0);
        end
        rd(20'hC0, d); check("R1 enable", d, 32'h0);
        rd(20'hD0, d); check("R1 pending", d, 32'h0);
    endtask

    task automatic t_store();
        logic [31:0] d;
        for (int i = 0; i < 10; i++)
            wr({12'h0, STORE_OFF[i]}, 32'hA5000000 ^ (32'h01010101 * (i + 1)));
        for (int i = 0; i < 10; i++) begin
            rd({12'h0, STORE_OFF[i]}, d);
            check("R2 readback", d, 32'hA5000000 ^ (32'h01010101 * (i + 1)));
        end
        @(posedge clk); @(negedge clk);
        check("R2 idle zero", bus_rdata, 32'h0);
    endtask

    task automatic t_filters();
        logic [31:0] d;
        wr(20'hC0, 32'hFFFF_FFFF); rd(20'hC0, d); check("R3 enable filter", d, 32'h000F_EEFF);
        wr(20'hD0, 32'hFFFF_FFFF); rd(20'hD0, d); check("R4 pending filter", d, 32'h000F_EEFF);
        wr(20'hD0, 32'h0000_1230); rd(20'hD0, d); check("R4 pending write", d, 32'h0000_0230);
        wr(20'hD0, 32'h0);
    endtask

    task automatic t_capture();
        logic [31:0] d;
        set_in(16'h0020);
        check("R5 parent rise", {31'b0, irq_parent}, 32'h1);
        rd(20'hD0, d); check("R5 pending", d, 32'h20);
        set_in(16'h0000);
        check("R5 parent fall", {31'b0, irq_parent}, 32'h0);
        rd(20'hD0, d); check("R5 pending fall", d, 32'h20);
        set_in(16'h0100);
        check("R3 line 8 parent", {31'b0, irq_parent}, 32'h0);
        rd(20'hD0, d); check("R3 line 8 pending", d, 32'h20);
        set_in(16'h0000);
        wr(20'hC0, 32'h0);
        set_in(16'h0004);
        check("R6 disabled parent", {31'b0, irq_parent}, 32'h0);
        rd(20'hD0, d); check("R6 disabled pending", d, 32'h20);
    endtask

    task automatic t_multi();
        logic [31:0] d;
        wr(20'hC0, 32'hFFFF);
        set_in(16'h4204);
        check("R7 parent", {31'b0, irq_parent}, 32'h1);
        rd(20'hD0, d); check("R7 lowest", d, 32'h200);
    endtask

    task automatic t_level_track();
        logic [31:0] d;
        wr(20'hC0, 32'h0);
        set_in(16'h0000);
        set_in(16'h0008);
        wr(20'hC0, 32'h8);
        @(posedge clk); @(negedge clk);
        check("R11 no event on enable", {31'b0, irq_parent}, 32'h1);
        rd(20'hD0, d); check("R11 pending held", d, 32'h200);
        set_in(16'h0000);
        check("R11 parent fall", {31'b0, irq_parent}, 32'h0);
        rd(20'hD0, d); check("R11 pending line 3", d, 32'h8);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(20'h0010, 32'h1111_2222);
        wr(20'h0020, 32'hDEAD_BEEF);
        wr(20'h0012, 32'hDEAD_BEEF);
        rd(20'h0020, d); check("R8 unmapped read", d, 32'h0);
        rd(20'h0012, d); check("R8 misaligned read", d, 32'h0);
        rd(20'h0010, d); check("R8 neighbour intact", d, 32'h1111_2222);
        rd(20'h00C0, d); check("R8 enable intact", d, 32'h8);
    endtask

    task automatic t_alias();
        logic [31:0] d;
        wr(20'hABC10, 32'h7777_0001);
        rd(20'h00010, d); check("R9 alias write", d, 32'h7777_0001);
        rd(20'h55514, d); check("R9 alias read", d, 32'hA5000000 ^ 32'h02020202);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        wr(20'hC0, 32'hFFFF);
        bus_addr = 20'hD0; bus_wdata = 32'hF0; bus_wr = 1'b1;
        irq_in = 16'h0001;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
        check("R10 parent", {31'b0, irq_parent}, 32'h1);
        rd(20'hD0, d); check("R10 capture wins", d, 32'h1);
        // mask write on same edge as a change: old mask (all on) judges it
        bus_addr = 20'hC0; bus_wdata = 32'h0; bus_wr = 1'b1;
        irq_in = 16'h0003;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
        rd(20'hD0, d); check("R10 mask overlap", d, 32'h2);
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_store();
        t_filters();
        wr(20'hC0, 32'hFFFF);
        t_capture();
        t_multi();
        t_level_track();
        t_unmapped();
        t_alias();
        t_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule